// File: doc/BRIEF.md
# Interrupt Vector Fetch Sequencer

This block turns an 8-bit interrupt type number into a far jump target. A one-cycle start strobe carries the type number. The block then reads that type's four-byte pointer entry from a table at the bottom of the 20-bit physical address space. It uses a byte-wide memory read port that can insert any number of wait cycles. The two bytes at the lower addresses of the entry form a 16-bit offset, and the two bytes above them form a 16-bit segment.

When the fourth byte is in, the block raises a one-cycle done pulse. During that cycle it presents the new segment, the new offset and the 20-bit physical target, which is the segment shifted left by four plus the offset. It keeps these values until the next fetch starts to overwrite them. Interrupt arbitration, acknowledge cycles and saving the return context belong to neighbouring logic.

Top module: `vector_fetch_seq`

## Requirements
- R1: While the synchronous reset is high and in the cycle after it, busy, done and memReq are 0, and newSeg, newOff and targetAddr are 0.
- R2: When startReq is high at a clock edge while busy is 0, the block enters the fetch in the next cycle. busy and memReq are 1 and memAddr equals the type number times 4 (table base 0).
- R3: A fetch issues exactly four reads, at base+0, base+1, base+2 and base+3 in that order. Each address is held with memReq high until memReady is sampled high on a clock edge, which captures memRdata. The next read is presented in the cycle that follows.
- R4: The byte at base+0 is the offset low byte and the byte at base+1 is the offset high byte. The byte at base+2 is the segment low byte and the byte at base+3 is the segment high byte.
- R5: done is high for exactly one cycle, the cycle after the fourth byte is captured. busy and memReq are 0 in that cycle.
- R6: targetAddr equals newSeg times 16 plus newOff, truncated to 20 bits (segment FFFFh with offset FFFFh gives 0FFEFh).
- R7: A startReq that arrives while busy is 1 has no effect: the running fetch continues at its own addresses and ends with a single done.
- R8: memReq is high only while busy is 1, and every address it presents lies in 00000h..003FFh.
- R9: Raising reset in the middle of a fetch returns the block to idle on the next edge and abandons the fetch.
- R10: After done, newSeg, newOff and targetAddr hold their values until the first byte of a later fetch is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Start strobe, accepted only while idle |
| startType | input | 8 | Interrupt type number that goes with startReq |
| memReq | output | 1 | Byte read request |
| memAddr | output | 20 | Byte read address |
| memRdata | input | 8 | Read data, captured when memReady is high |
| memReady | input | 1 | Memory has the data of the current read |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle result strobe |
| newSeg | output | 16 | Assembled segment word |
| newOff | output | 16 | Assembled offset word |
| targetAddr | output | 20 | Segment times 16 plus offset, 20 bits |

## Verification
The bench uses the default parameters: an 8-bit type, a 20-bit address and a table at address 0. With these, type FFh reaches the very top entry at 003FCh, and an all-ones entry drives the target adder past 20 bits so that it wraps. The memory model answers with zero, one or several wait cycles. This tests address holding during waits and the change of address on the cycle after each capture. Back-to-back starts placed in the done cycle, starts sent during a fetch and a reset in the middle of a fetch cover the control edges.

// File: rtl/ivf_pkg.sv
package ivf_pkg;

  localparam int ENTRY_BYTES = 4;
  localparam int IDX_W = $clog2(ENTRY_BYTES);
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } ivfState_t;

  typedef struct packed {
    logic             loadType;
    logic             fetchActive;
    logic             captureByte;
    logic [IDX_W-1:0] byteIdx;
  } ivfCtl_t;

endpackage

// File: rtl/ivf_ctrl.sv
module ivf_ctrl
  import ivf_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    startReq,
  input  logic    memReady,
  output ivfCtl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    memReq
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_BYTES - 1);

  ivfState_t state, stateNext;
  logic [IDX_W-1:0] idx;
  logic accept;
  logic capture;
  logic lastByte;

  assign accept   = startReq && (state != ST_FETCH);
  assign capture  = (state == ST_FETCH) && memReady;
  assign lastByte = (idx == LAST_IDX);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (accept) stateNext = ST_FETCH;
      ST_FETCH: if (capture && lastByte) stateNext = ST_DONE;
      ST_DONE:  stateNext = accept ? ST_FETCH : ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= stateNext;
      if (accept)       idx <= '0;
      else if (capture) idx <= idx + 1'b1;
    end
  end

  assign busy   = (state == ST_FETCH);
  assign memReq = (state == ST_FETCH);
  assign done   = (state == ST_DONE);

  assign ctl.loadType    = accept;
  assign ctl.fetchActive = (state == ST_FETCH);
  assign ctl.captureByte = capture;
  assign ctl.byteIdx     = idx;

  // R5: the result strobe never lasts two cycles
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: done only follows a capture of the final byte
  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && !(capture && lastByte)) |=> !done);

  // R8: requests only during a fetch
  assert_req_only_busy_R8: assert property (@(posedge clk) disable iff (rst)
    memReq |-> busy);

  // R7: a start during a fetch cannot cut the fetch short
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && startReq && !capture) |=> (busy && $stable(idx)));

  // R9: reset always lands in idle
  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (!busy && !done && !memReq));

endmodule

// File: rtl/ivf_datapath.sv
module ivf_datapath
  import ivf_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16,
  parameter int SEG_SHIFT = 4,
  parameter logic [ADDR_W-1:0] TABLE_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  ivfCtl_t           ctl,
  input  logic [TYPE_W-1:0] startType,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] newSeg,
  output logic [WORD_W-1:0] newOff,
  output logic [ADDR_W-1:0] targetAddr
);

  localparam int HALF_BYTES = WORD_W / BYTE_W;
  localparam longint TABLE_BYTES = longint'(1) << (TYPE_W + IDX_W);
  localparam longint TABLE_END = longint'(TABLE_BASE) + TABLE_BYTES;

  logic [TYPE_W-1:0] typeReg;
  logic [BYTE_W-1:0] entryBytes [ENTRY_BYTES];

  always_ff @(posedge clk) begin
    if (rst) typeReg <= '0;
    else if (ctl.loadType) typeReg <= startType;
  end

  for (genvar b = 0; b < ENTRY_BYTES; b++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) entryBytes[b] <= '0;
      else if (ctl.captureByte && ctl.byteIdx == IDX_W'(b)) entryBytes[b] <= memRdata;
    end
  end

  for (genvar h = 0; h < HALF_BYTES; h++) begin : g_words
    assign newOff[h*BYTE_W +: BYTE_W] = entryBytes[h];
    assign newSeg[h*BYTE_W +: BYTE_W] = entryBytes[HALF_BYTES + h];
  end

  assign memAddr = TABLE_BASE + ADDR_W'({typeReg, ctl.byteIdx});

  logic [ADDR_W-1:0] segScaled;
  assign segScaled  = ADDR_W'({newSeg, {SEG_SHIFT{1'b0}}});
  assign targetAddr = segScaled + ADDR_W'(newOff);

  // R3: a waiting read keeps its address
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl.fetchActive && !ctl.captureByte) |=> $stable(memAddr));

  // R3: after a non-final capture the address moves up by one
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl.fetchActive && ctl.captureByte && ctl.byteIdx != IDX_W'(ENTRY_BYTES-1))
      |=> (memAddr == $past(memAddr) + 1'b1));

  // R8: every request stays inside the vector table
  assert_table_range_R8: assert property (@(posedge clk) disable iff (rst)
    ctl.fetchActive |-> (longint'(memAddr) >= longint'(TABLE_BASE) &&
                         longint'(memAddr) < TABLE_END));

  // R10: results change only by a capture
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !ctl.captureByte |=> ($stable(newSeg) && $stable(newOff)));

endmodule

// File: rtl/vector_fetch_seq.sv
module vector_fetch_seq
  import ivf_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16,
  parameter int SEG_SHIFT = 4,
  parameter logic [ADDR_W-1:0] TABLE_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic [TYPE_W-1:0] startType,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memRdata,
  input  logic              memReady,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] newSeg,
  output logic [WORD_W-1:0] newOff,
  output logic [ADDR_W-1:0] targetAddr
);

  ivfCtl_t ctl;

  ivf_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .memReady (memReady),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done),
    .memReq   (memReq)
  );

  ivf_datapath #(
    .TYPE_W     (TYPE_W),
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .SEG_SHIFT  (SEG_SHIFT),
    .TABLE_BASE (TABLE_BASE)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .startType  (startType),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .newSeg     (newSeg),
    .newOff     (newOff),
    .targetAddr (targetAddr)
  );

endmodule

// File: tb/vector_fetch_seq_tb.sv
module vector_fetch_seq_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic        startReq;
  logic [7:0]  startType;
  logic        memReq;
  logic [19:0] memAddr;
  logic [7:0]  memRdata;
  logic        memReady;
  logic        busy, done;
  logic [15:0] newSeg, newOff;
  logic [19:0] targetAddr;

  vector_fetch_seq dut_i (
    .clk(clk), .rst(rst), .startReq(startReq), .startType(startType),
    .memReq(memReq), .memAddr(memAddr), .memRdata(memRdata), .memReady(memReady),
    .busy(busy), .done(done), .newSeg(newSeg), .newOff(newOff), .targetAddr(targetAddr)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] mem [0:1023];
  always_comb memRdata = memReq ? mem[memAddr[9:0]] : 8'h00;

  int waitN = 0;
  int readyCnt = 0;
  always @(negedge clk) begin
    #1;
    readyCnt = readyCnt + 1;
    memReady = ((readyCnt % (waitN + 1)) == waitN);
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model: 0 idle, 1 fetching, 2 done
  int mState = 0;
  int mIdx = 0;
  int mType = 0;
  int mByte [4];
  bit modelLive = 0;

  always @(posedge clk) begin
    modelLive <= 1;
    if (rst) begin
      mState = 0; mIdx = 0;
      for (int k = 0; k < 4; k++) mByte[k] = 0;
    end else begin
      case (mState)
        1: if (memReady) begin
             mByte[mIdx] = memRdata;
             if (mIdx == 3) mState = 2; else mIdx = mIdx + 1;
           end
        default: if (startReq) begin
             mState = 1; mIdx = 0; mType = startType;
           end else mState = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (modelLive && !finished) begin
      int off, seg;
      off = mByte[0] + 256 * mByte[1];
      seg = mByte[2] + 256 * mByte[3];
      chk("R2 busy", busy, mState == 1);
      chk("R8 memReq", memReq, mState == 1);
      chk("R5 done", done, mState == 2);
      if (mState == 1) chk("R3 memAddr", memAddr, mType * 4 + mIdx);
      else begin
        chk("R4 newOff", newOff, off);
        chk("R4 newSeg", newSeg, seg);
        chk("R6 targetAddr", targetAddr, (seg * 16 + off) & 20'hFFFFF);
      end
    end
  end

  task automatic tick(); @(negedge clk); #2; endtask

  task automatic startFetch(input logic [7:0] t);
    startReq = 1; startType = t;
    tick();
    startReq = 0; startType = 8'h00;
  endtask

  task automatic waitDone(output bit seen);
    seen = 0;
    for (int c = 0; c < 200 && !seen; c++) begin
      if (done) seen = 1; else tick();
    end
  endtask

  function automatic int entryOff(input int t);
    return mem[t*4] + 256 * mem[t*4+1];
  endfunction
  function automatic int entrySeg(input int t);
    return mem[t*4+2] + 256 * mem[t*4+3];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 29 + 7) & 8'hFF);
    for (int i = 1020; i < 1024; i++) mem[i] = 8'hFF;
    rst = 1; startReq = 0; startType = 0; memReady = 0;
    repeat (2) tick();
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 memReq in reset", memReq, 0);
    chk("R1 targetAddr in reset", targetAddr, 0);
    rst = 0;
    tick();

    // type 0, no wait states
    waitN = 0;
    startFetch(8'h00);
    chk("R2 base address type 0", memAddr, 0);
    waitDone(seen);
    chk("R5 done seen type 0", seen, 1);
    chk("R4 offset type 0", newOff, entryOff(0));
    chk("R4 segment type 0", newSeg, entrySeg(0));
    tick();
    chk("R5 done single cycle", done, 0);

    // type 21h, two wait cycles per read
    waitN = 2;
    startFetch(8'h21);
    chk("R2 base address type 21h", memAddr, 20'h84);
    waitDone(seen);
    chk("R5 done seen type 21h", seen, 1);
    chk("R6 target type 21h", targetAddr,
        (entrySeg(33) * 16 + entryOff(33)) & 20'hFFFFF);
    repeat (5) tick();
    chk("R10 segment held", newSeg, entrySeg(33));

    // top entry, all ones, target wraps
    waitN = 1;
    startFetch(8'hFF);
    chk("R8 top entry address", memAddr, 20'h003FC);
    waitDone(seen);
    chk("R6 wrapped target", targetAddr, 20'h0FFEF);
    chk("R4 all-ones segment", newSeg, 16'hFFFF);

    // start during a fetch is ignored, new start in the done cycle accepted
    waitN = 3;
    startFetch(8'h10);
    startReq = 1; startType = 8'h55;
    repeat (4) tick();
    chk("R7 address unaffected", memAddr[19:2], 18'h10);
    startReq = 0;
    waitDone(seen);
    chk("R7 result from first type", newOff, entryOff(16));
    startFetch(8'h02);
    chk("R2 start in done cycle", busy, 1);
    waitDone(seen);
    chk("R4 back-to-back segment", newSeg, entrySeg(2));

    // reset in the middle of a fetch
    waitN = 2;
    startFetch(8'h40);
    repeat (3) tick();
    rst = 1;
    tick();
    rst = 0;
    chk("R9 idle after reset", busy, 0);
    chk("R9 no request after reset", memReq, 0);
    repeat (3) tick();
    chk("R9 stays idle", done, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule